// File: doc/BRIEF.md
# Toggle-Handshake Single-Port RAM

This block is a single-port synchronous memory placed next to a rising-edge controller. The client does not raise a level valid. It asks for an access by making its request bit, `reqToggle`, differ from the acknowledge bit, `ackToggle`, that the memory holds. The memory serves the request by performing either a load or a store, as `wrSel` selects. It then copies the request bit into the acknowledge bit, which clears the mismatch. Every later access needs the client to invert `reqToggle` again.

The memory logic runs on the falling clock edge. A request that the controller drives just after a rising edge is therefore complete, with its acknowledge and any loaded word visible, before the next rising edge.

The storage array is reached only through one write port and one registered read port, with one access per cycle. This lets synthesis map it onto a dedicated RAM. Word width and depth are parameters (32 bits and 1024 words by default), and the address width is the base-2 logarithm of the depth.

Top module: `toggle_ram`

## Requirements
- R1: While `ackToggle` equals `reqToggle` the block is idle. `rdData` and every array word keep their values, whatever `wrSel`, `addr` and `wrData` carry.
- R2: When the two bits differ and `wrSel` is 0 (load), `rdData` takes the word stored at `addr`, and `ackToggle` takes the value of `reqToggle`.
- R3: When the two bits differ and `wrSel` is 1 (store), `wrData` is written to the word at `addr`, `ackToggle` takes the value of `reqToggle`, and `rdData` keeps its value.
- R4: A request is served exactly once. If `reqToggle` is held after it has been served, no further access takes place, even when `wrData` or `addr` change.
- R5: The block acts on the falling clock edge. A request driven after a rising edge shows its effect on `ackToggle` and `rdData` at the next rising edge.
- R6: A synchronous active-high `rst`, sampled on the falling edge, clears `ackToggle` and `rdData` to 0. No access takes place in a cycle where `rst` is high, and the array contents survive the reset.
- R7: A store followed in the very next cycle by a load from the same address returns the newly stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the memory acts on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| reqToggle | input | 1 | Client request bit; a change opens a request |
| wrSel | input | 1 | 1 selects a store, 0 selects a load |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Word to store |
| ackToggle | output | 1 | Acknowledge bit; equals `reqToggle` when no request is open |
| rdData | output | DATA_W | Registered result of the latest load |

## Verification
The assertions take for granted that the client changes `reqToggle`, `wrSel`, `addr` and `wrData` only in the half cycle after a rising edge, so the inputs are steady at each falling edge. They also assume every address lies below the depth. The stimulus drives all inputs one nanosecond after a rising edge and uses only in-range addresses. Before each reset it returns `reqToggle` to 0, so no request is left open when reset is released.

// File: rtl/toggle_ram_pkg.sv
package toggle_ram_pkg;
  typedef struct packed {
    logic doLoad;
    logic doStore;
  } ramStrobe_t;
endpackage

// File: rtl/toggle_ram_ctrl.sv
module toggle_ram_ctrl
  import toggle_ram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqToggle,
  input  logic       wrSel,
  output logic       ackToggle,
  output ramStrobe_t strobe
);
  logic ackReg;
  logic pending;

  assign pending        = (reqToggle != ackReg) && !rst;
  assign strobe.doLoad  = pending && !wrSel;
  assign strobe.doStore = pending && wrSel;
  assign ackToggle      = ackReg;

  always_ff @(negedge clk) begin
    if (rst)          ackReg <= 1'b0;
    else if (pending) ackReg <= reqToggle;
  end

  // R4
  ack_follows_req_chk: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> (ackToggle == $past(reqToggle)));

  // R1
  ack_moves_only_on_request_chk: assert property (@(negedge clk) disable iff (rst)
    (reqToggle == ackToggle) |=> $stable(ackToggle));
endmodule

// File: rtl/toggle_ram_dp.sv
module toggle_ram_dp
  import toggle_ram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  ramStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] memArray [DEPTH];

  always_ff @(negedge clk) begin
    if (strobe.doStore) memArray[addr] <= wrData;
  end

  always_ff @(negedge clk) begin
    if (rst)                rdData <= '0;
    else if (strobe.doLoad) rdData <= memArray[addr];
  end

  // R2
  single_strobe_chk: assert property (@(negedge clk) disable iff (rst)
    $onehot0({strobe.doLoad, strobe.doStore}));

  // R3
  rd_held_without_load_chk: assert property (@(negedge clk) disable iff (rst)
    !strobe.doLoad |=> $stable(rdData));
endmodule

// File: rtl/toggle_ram.sv
module toggle_ram
  import toggle_ram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqToggle,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic              ackToggle,
  output logic [DATA_W-1:0] rdData
);
  ramStrobe_t strobe;

  toggle_ram_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqToggle (reqToggle),
    .wrSel     (wrSel),
    .ackToggle (ackToggle),
    .strobe    (strobe)
  );

  toggle_ram_dp #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: tb/sim_toggle_ram.sv
module sim_toggle_ram;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1024;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqT = 1'b0;
  logic wrSel = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic ackT;
  logic [DATA_W-1:0] rdData;

  int tests = 0;
  int fails = 0;

  // reference state
  logic [DATA_W-1:0] refMem [int];
  logic refAck = 1'b0;
  logic [DATA_W-1:0] refRd = '0;

  always #4 clk = ~clk;

  toggle_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .reqToggle(reqT), .wrSel(wrSel), .addr(addr),
    .wrData(wrData), .ackToggle(ackT), .rdData(rdData)
  );

  task automatic checkNow(string tag);
    tests++;
    if (ackT !== refAck) begin
      fails++;
      $display("FAIL %s ackToggle actual=%0b expected=%0b", tag, ackT, refAck);
    end
    tests++;
    if (rdData !== refRd) begin
      fails++;
      $display("FAIL %s rdData actual=%h expected=%h", tag, rdData, refRd);
    end
  endtask

  // drive after a rising edge, model the falling-edge action, compare at next rising edge (R5)
  task automatic step(logic r, logic wr, int a, logic [DATA_W-1:0] d, string tag);
    #1;
    reqT = r; wrSel = wr; addr = ADDR_W'(a); wrData = d;
    @(posedge clk);
    if (rst) begin
      refAck = 1'b0; refRd = '0;
    end else if (reqT != refAck) begin
      if (wrSel) refMem[a] = d;
      else refRd = refMem.exists(a) ? refMem[a] : 'x;
      refAck = reqT;
    end
    checkNow(tag);
  endtask

  task automatic store(int a, logic [DATA_W-1:0] d, string tag);
    step(!reqT, 1'b1, a, d, tag);
  endtask

  task automatic load(int a, string tag);
    step(!reqT, 1'b0, a, '0, tag);
  endtask

  task automatic holdReq(logic wr, int a, logic [DATA_W-1:0] d, string tag);
    step(reqT, wr, a, d, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R6 reset state
    rst = 1'b1;
    repeat (2) step(1'b0, 1'b0, 0, '0, "R6 reset");
    #1 rst = 1'b0;
    @(posedge clk);
    checkNow("R6 after release");

    // R3 stores over several addresses, R2 loads back
    for (int i = 0; i < 8; i++) store(i * 131, 32'hA500_0000 + i * 32'h1111, "R3 store");
    for (int i = 7; i >= 0; i--) load(i * 131, "R2 load");
    store(0, 32'hFFFF_FFFF, "R3 store lowest");
    store(DEPTH - 1, 32'h0BAD_F00D, "R3 store highest");
    load(DEPTH - 1, "R2 load highest");
    load(0, "R2 load lowest");

    // R3 store does not disturb rdData
    load(131, "R2 load before store");
    store(262, 32'h1234_5678, "R3 rdData kept on store");

    // R7 back-to-back store then load to the same address
    for (int i = 0; i < 6; i++) begin
      store(40 + i, 32'hC0DE_0000 ^ (i * 32'h0101_0101), "R7 store");
      load(40 + i, "R7 load");
    end

    // R1 idle with changing wrSel, addr, wrData
    holdReq(1'b1, 40, 32'hDEAD_BEEF, "R1 idle store-select");
    holdReq(1'b0, 131, '0, "R1 idle load-select");
    load(40, "R1 word intact");

    // R4 request held after a store: later data must not land
    store(500, 32'h5555_AAAA, "R4 store");
    holdReq(1'b1, 500, 32'h0000_0001, "R4 held same addr");
    holdReq(1'b1, 501, 32'h0000_0002, "R4 held other addr");
    load(500, "R4 single store");
    store(501, 32'h7777_0000, "R4 store 501");
    load(501, "R4 load 501");
    holdReq(1'b0, 500, '0, "R4 held load no reload");

    // R6 mid-run reset: clears outputs, keeps array
    #1 reqT = 1'b0; rst = 1'b1;
    @(posedge clk);
    refAck = 1'b0; refRd = '0;
    checkNow("R6 mid reset");
    #1 rst = 1'b0;
    @(posedge clk);
    checkNow("R6 mid release");
    load(500, "R6 array kept");
    load(2 * 131, "R6 array kept 2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule